// File: doc/BRIEF.md
# Multi-Endpoint Packet Buffer Access Window

This block gives a processor byte, halfword and word access to packet buffers for a set of endpoints. All the buffers live in one shared, byte-addressed single-port RAM. Every endpoint owns a transmit buffer and a receive buffer. Each buffer has a programmable base address, a start offset and a running count. A write to an endpoint's slot in the data window appends bytes to its transmit buffer. A read from the slot takes bytes from its receive buffer. A wider access is split into single-byte steps, one per clock. Each step checks the packet-length limit on its own.

The surrounding controller signals packet boundaries through an event port. A "done" event moves the start offset past the bytes just handled and clears the count, so the next packet follows straight on in the buffer. A "load" event marks a receive buffer as full. Two per-endpoint status vectors show transmit-not-empty and receive-full. The bus is a request/acknowledge pair. A request is accepted while `bus_ready` is high. The acknowledge pulse marks completion and carries the read data.

Top module: `ep_fifo_window`

## Requirements
- R1: After reset, `bus_ready` is 1, `bus_ack` is 0 and both status vectors are 0. Every base, start and count is 0, so a base register reads back 0.
- R2: Addresses 0x40 to 0x7F form the data window. The endpoint is (addr - 0x40) >> 2, so all four byte offsets of a 4-byte slot reach the same endpoint.
- R3: A write of size byte (`bus_size`=0), halfword (1) or word (2) pushes bytes of `bus_wdata` lowest byte first. Each byte goes to RAM location base + start + count, and count then rises by one.
- R4: A read of size byte, halfword or word pops consecutive bytes from base + start + count. The first byte popped lands in `bus_rdata[7:0]`, the next ones in the following byte lanes, and lanes that were not read return 0.
- R5: A transmit push is discarded, with no RAM write and no count change, when the packet already holds 64 bytes.
- R6: A receive pop that finds 64 bytes already drained returns 0x00 for that byte and does not advance the count.
- R7: Every accepted push sets `tx_not_empty[ep]`. A transmit-done event (`evt_kind`=0) clears it.
- R8: Every receive pop clears `rx_full[ep]`. A receive-load event (`evt_kind`=2) sets it.
- R9: A halfword write to 0x80 + 4*ep sets that endpoint's transmit base, and one to 0x82 + 4*ep sets its receive base. The stored base is (value << 3) & 0x7FF. A read of either register returns the stored base. A byte or word write there is ignored.
- R10: A transmit-done event (`evt_kind`=0) or receive-done event (`evt_kind`=1) on an endpoint adds that direction's count to its start and clears the count.
- R11: An address outside the window and the base registers, or a `bus_size` of 3, reads as 0 and has no effect when written.
- R12: A request is accepted on a clock edge where `bus_ready` and `bus_req` are both high. `bus_ready` is then low until `bus_ack` rises. `bus_ack` is a one-cycle pulse on the (N+1)th edge after acceptance, where N is 1, 2 or 4 bytes for window accesses and 1 for all others.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_req | input | 1 | Access request, taken while bus_ready is high |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 invalid |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data, byte 0 in bits [7:0] |
| bus_ready | output | 1 | Engine idle, able to take a request |
| bus_ack | output | 1 | One-cycle completion pulse |
| bus_rdata | output | 32 | Read result, valid with bus_ack |
| evt_valid | input | 1 | Packet event strobe |
| evt_ep | input | 4 | Endpoint of the event |
| evt_kind | input | 2 | 0 transmit done, 1 receive done, 2 receive load, 3 none |
| tx_not_empty | output | 16 | Per-endpoint transmit-not-empty flags |
| rx_full | output | 16 | Per-endpoint receive-full flags |

## Verification
The data path is tried with word, halfword and byte pushes and pops mixed in one packet. This separates lane order from byte count. It also uses several addresses inside one slot, which shows whether endpoint decode ignores the low offset bits. A 64-byte packet followed by one extra push and one extra pop tests the limit. A done event and a single-byte probe then show whether the discarded push or the refused pop moved any count. Writes with invalid sizes, writes to unmapped addresses and byte writes to base registers are each followed by a readback or a flag check. This tells an ignored access apart from one that took effect.

// File: rtl/ep_fifo_pkg.sv
// Package: shared encodings for the endpoint buffer window.
// Assumes: all users import these types. They carry no state.
package ep_fifo_pkg;
    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_BAD  = 2'd3
    } acc_size_e;

    typedef enum logic [1:0] {
        EV_TX_DONE = 2'd0,
        EV_RX_DONE = 2'd1,
        EV_RX_LOAD = 2'd2,
        EV_NOP     = 2'd3
    } evt_kind_e;

    typedef enum logic [1:0] {
        TGT_NONE = 2'd0,
        TGT_FIFO = 2'd1,
        TGT_BASE = 2'd2
    } target_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_DRAIN = 2'd2
    } eng_state_e;
endpackage

// File: rtl/ep_addr_decode.sv
// Module: ep_addr_decode
// Purpose: classifies a bus address as a data-window slot, a base register
//          or unmapped. It also extracts the endpoint index and, for base
//          registers, the direction.
// Assumes: ADDR_W >= EP_W + 2. The two regions do not overlap.
module ep_addr_decode
    import ep_fifo_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int NUM_EP   = 16,
    parameter int EP_W     = 4,
    parameter int FIFO_OFS = 'h40,
    parameter int BASE_OFS = 'h80
) (
    input  logic [ADDR_W-1:0] addr,
    input  acc_size_e         size,
    output target_e           target,
    output logic [EP_W-1:0]   ep,
    output logic              dir_rx
);
    localparam int WIN = 4 * NUM_EP;

    logic [ADDR_W-1:0] fifo_off;
    logic [ADDR_W-1:0] base_off;

    assign fifo_off = addr - ADDR_W'(FIFO_OFS);
    assign base_off = addr - ADDR_W'(BASE_OFS);

    // Region match and field extraction.
    always_comb begin
        target = TGT_NONE;
        ep     = '0;
        dir_rx = 1'b0;
        if (size == SZ_BAD) begin
            target = TGT_NONE;
        end else if (int'(addr) >= FIFO_OFS && int'(addr) < FIFO_OFS + WIN) begin
            target = TGT_FIFO;
            ep     = fifo_off[EP_W+1:2];
        end else if (int'(addr) >= BASE_OFS && int'(addr) < BASE_OFS + WIN
                     && !addr[0]) begin
            target = TGT_BASE;
            ep     = base_off[EP_W+1:2];
            dir_rx = base_off[1];
        end
    end
endmodule

// File: rtl/ep_ptr_bank.sv
// Module: ep_ptr_bank
// Purpose: holds base, start and count for each endpoint and direction,
//          plus the not-empty and full flags. A single selector picks the
//          buffer touched by the bus engine.
// Assumes: RAM_DEPTH is a power of two, CNT_W <= RAM_AW <= 19, and the
//          caller raises op_valid only while the count is below the limit.
module ep_ptr_bank
    import ep_fifo_pkg::*;
#(
    parameter int NUM_EP = 16,
    parameter int EP_W   = 4,
    parameter int RAM_AW = 11,
    parameter int CNT_W  = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [EP_W-1:0]   sel_ep,
    input  logic              sel_rx,
    input  logic              op_valid,
    input  logic              bw_valid,
    input  logic [15:0]       bw_value,
    input  logic              evt_valid,
    input  logic [EP_W-1:0]   evt_ep,
    input  evt_kind_e         evt_kind,
    output logic [RAM_AW-1:0] sel_base,
    output logic [RAM_AW-1:0] sel_start,
    output logic [CNT_W-1:0]  sel_count,
    output logic [NUM_EP-1:0] tx_not_empty,
    output logic [NUM_EP-1:0] rx_full
);
    logic [RAM_AW-1:0] base_a  [NUM_EP][2];
    logic [RAM_AW-1:0] start_a [NUM_EP][2];
    logic [CNT_W-1:0]  count_a [NUM_EP][2];
    logic [18:0]       base_shift;

    assign base_shift = {bw_value, 3'b000};

    for (genvar e = 0; e < NUM_EP; e++) begin : g_ep
        for (genvar d = 0; d < 2; d++) begin : g_dir
            logic [RAM_AW-1:0] base_q;
            logic [RAM_AW-1:0] start_q;
            logic [CNT_W-1:0]  count_q;
            logic              hit;
            logic              done_hit;

            assign hit      = (sel_ep == EP_W'(e)) && (sel_rx == 1'(d));
            assign done_hit = evt_valid && (evt_ep == EP_W'(e)) &&
                              (evt_kind == ((d == 1) ? EV_RX_DONE : EV_TX_DONE));

            // Buffer pointers: base load, packet advance, byte count.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    base_q  <= '0;
                    start_q <= '0;
                    count_q <= '0;
                end else begin
                    if (bw_valid && hit)
                        base_q <= base_shift[RAM_AW-1:0];
                    if (done_hit) begin
                        start_q <= start_q + {{(RAM_AW-CNT_W){1'b0}}, count_q};
                        count_q <= '0;
                    end else if (op_valid && hit) begin
                        count_q <= count_q + CNT_W'(1);
                    end
                end
            end

            assign base_a[e][d]  = base_q;
            assign start_a[e][d] = start_q;
            assign count_a[e][d] = count_q;
        end

        logic ne_q;
        logic full_q;

        // Status flags: set or clear by bus bytes and packet events.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ne_q   <= 1'b0;
                full_q <= 1'b0;
            end else begin
                if (evt_valid && evt_ep == EP_W'(e) && evt_kind == EV_TX_DONE)
                    ne_q <= 1'b0;
                else if (op_valid && sel_ep == EP_W'(e) && !sel_rx)
                    ne_q <= 1'b1;
                if (evt_valid && evt_ep == EP_W'(e) && evt_kind == EV_RX_LOAD)
                    full_q <= 1'b1;
                else if (op_valid && sel_ep == EP_W'(e) && sel_rx)
                    full_q <= 1'b0;
            end
        end

        assign tx_not_empty[e] = ne_q;
        assign rx_full[e]      = full_q;
    end

    assign sel_base  = base_a[sel_ep][sel_rx];
    assign sel_start = start_a[sel_ep][sel_rx];
    assign sel_count = count_a[sel_ep][sel_rx];
endmodule

// File: rtl/ep_byte_ram.sv
// Module: ep_byte_ram
// Purpose: a single-port byte RAM with a registered read port, shared by
//          all endpoint buffers.
// Assumes: one access per cycle. The contents are not reset.
module ep_byte_ram #(
    parameter int DEPTH = 2048,
    parameter int AW    = 11
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [7:0]    wdata,
    output logic [7:0]    rdata
);
    logic [7:0] mem [DEPTH];

    // Write or read one byte each cycle.
    always_ff @(posedge clk) begin
        if (we)
            mem[addr] <= wdata;
        rdata <= mem[addr];
    end
endmodule

// File: rtl/ep_fifo_window.sv
// Module: ep_fifo_window
// Purpose: bus access engine. It takes one request, splits it into
//          single-byte pushes or pops against the shared RAM (lowest byte
//          first), assembles read data and returns a one-cycle acknowledge.
// Assumes: a request is held only while bus_ready is high. Packet events
//          are not issued while a bus access on the same buffer is in
//          flight; if they are, the event takes priority for the count.
module ep_fifo_window
    import ep_fifo_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int NUM_EP    = 16,
    parameter int RAM_DEPTH = 2048,
    parameter int PKT_LIMIT = 64,
    parameter int FIFO_OFS  = 'h40,
    parameter int BASE_OFS  = 'h80,
    localparam int EP_W     = $clog2(NUM_EP),
    localparam int RAM_AW   = $clog2(RAM_DEPTH),
    localparam int CNT_W    = $clog2(PKT_LIMIT + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic [1:0]        bus_size,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic              bus_ready,
    output logic              bus_ack,
    output logic [31:0]       bus_rdata,
    input  logic              evt_valid,
    input  logic [EP_W-1:0]   evt_ep,
    input  logic [1:0]        evt_kind,
    output logic [NUM_EP-1:0] tx_not_empty,
    output logic [NUM_EP-1:0] rx_full
);
    eng_state_e        state_q;
    target_e           tgt_q;
    acc_size_e         size_q;
    logic              we_q;
    logic [EP_W-1:0]   ep_q;
    logic              rx_q;
    logic [2:0]        nbytes_q;
    logic [1:0]        idx_q;
    logic [31:0]       wdata_q;
    logic              ack_q;
    logic [31:0]       rdata_q;
    logic              rd_act_q;
    logic              rd_ok_q;
    logic [1:0]        rd_lane_q;

    target_e           dec_tgt;
    logic [EP_W-1:0]   dec_ep;
    logic              dec_rx;
    logic [2:0]        dec_nbytes;

    logic              accept;
    logic              last_byte;
    logic              sel_rx;
    logic              fifo_op;
    logic              byte_ok;
    logic              ram_we;
    logic              bw_valid;
    logic [RAM_AW-1:0] ram_addr;
    logic [7:0]        ram_wdata;
    logic [7:0]        ram_rdata;
    logic [RAM_AW-1:0] sel_base;
    logic [RAM_AW-1:0] sel_start;
    logic [CNT_W-1:0]  sel_count;

    ep_addr_decode #(
        .ADDR_W  (ADDR_W),
        .NUM_EP  (NUM_EP),
        .EP_W    (EP_W),
        .FIFO_OFS(FIFO_OFS),
        .BASE_OFS(BASE_OFS)
    ) u_dec (
        .addr  (bus_addr),
        .size  (acc_size_e'(bus_size)),
        .target(dec_tgt),
        .ep    (dec_ep),
        .dir_rx(dec_rx)
    );

    // Byte count of the incoming request.
    always_comb begin
        dec_nbytes = 3'd1;
        if (dec_tgt == TGT_FIFO) begin
            case (acc_size_e'(bus_size))
                SZ_HALF: dec_nbytes = 3'd2;
                SZ_WORD: dec_nbytes = 3'd4;
                default: dec_nbytes = 3'd1;
            endcase
        end
    end

    assign accept    = (state_q == ST_IDLE) && bus_req;
    assign last_byte = ({1'b0, idx_q} == nbytes_q - 3'd1);
    assign sel_rx    = (tgt_q == TGT_FIFO) ? !we_q : rx_q;
    assign fifo_op   = (state_q == ST_RUN) && (tgt_q == TGT_FIFO);
    assign byte_ok   = fifo_op && (int'(sel_count) < PKT_LIMIT);
    assign ram_we    = byte_ok && we_q;
    assign bw_valid  = (state_q == ST_RUN) && (tgt_q == TGT_BASE) && we_q &&
                       (size_q == SZ_HALF);
    assign ram_addr  = sel_base + sel_start + {{(RAM_AW-CNT_W){1'b0}}, sel_count};
    assign ram_wdata = wdata_q[{idx_q, 3'b000} +: 8];

    ep_ptr_bank #(
        .NUM_EP(NUM_EP),
        .EP_W  (EP_W),
        .RAM_AW(RAM_AW),
        .CNT_W (CNT_W)
    ) u_bank (
        .clk         (clk),
        .rst_n       (rst_n),
        .sel_ep      (ep_q),
        .sel_rx      (sel_rx),
        .op_valid    (byte_ok),
        .bw_valid    (bw_valid),
        .bw_value    (wdata_q[15:0]),
        .evt_valid   (evt_valid),
        .evt_ep      (evt_ep),
        .evt_kind    (evt_kind_e'(evt_kind)),
        .sel_base    (sel_base),
        .sel_start   (sel_start),
        .sel_count   (sel_count),
        .tx_not_empty(tx_not_empty),
        .rx_full     (rx_full)
    );

    ep_byte_ram #(
        .DEPTH(RAM_DEPTH),
        .AW   (RAM_AW)
    ) u_ram (
        .clk  (clk),
        .we   (ram_we),
        .addr (ram_addr),
        .wdata(ram_wdata),
        .rdata(ram_rdata)
    );

    // Engine sequencing: idle, one cycle per byte, then one drain cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            tgt_q    <= TGT_NONE;
            size_q   <= SZ_BYTE;
            we_q     <= 1'b0;
            ep_q     <= '0;
            rx_q     <= 1'b0;
            nbytes_q <= 3'd1;
            idx_q    <= '0;
            wdata_q  <= '0;
            ack_q    <= 1'b0;
        end else begin
            ack_q <= (state_q == ST_DRAIN);
            case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        state_q  <= ST_RUN;
                        tgt_q    <= dec_tgt;
                        size_q   <= acc_size_e'(bus_size);
                        we_q     <= bus_we;
                        ep_q     <= dec_ep;
                        rx_q     <= dec_rx;
                        nbytes_q <= dec_nbytes;
                        idx_q    <= '0;
                        wdata_q  <= bus_wdata;
                    end
                end
                ST_RUN: begin
                    if (last_byte)
                        state_q <= ST_DRAIN;
                    else
                        idx_q <= idx_q + 2'd1;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Read pipeline: remember which lane the RAM output belongs to.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_act_q  <= 1'b0;
            rd_ok_q   <= 1'b0;
            rd_lane_q <= '0;
        end else begin
            rd_act_q  <= fifo_op && !we_q;
            rd_ok_q   <= byte_ok;
            rd_lane_q <= idx_q;
        end
    end

    // Result assembly: clear on accept, then fill lanes or load a base value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (accept) begin
            rdata_q <= '0;
        end else if ((state_q == ST_RUN) && (tgt_q == TGT_BASE) && !we_q) begin
            rdata_q <= {{(32-RAM_AW){1'b0}}, sel_base};
        end else if (rd_act_q) begin
            rdata_q[{rd_lane_q, 3'b000} +: 8] <= rd_ok_q ? ram_rdata : 8'h00;
        end
    end

    assign bus_ready = (state_q == ST_IDLE);
    assign bus_ack   = ack_q;
    assign bus_rdata = rdata_q;
endmodule

// File: rtl/ep_fifo_window_chk.sv
// Module: ep_fifo_window_chk
// Purpose: protocol and status properties of the buffer window. It is
//          bound into every instance of the top module.
// Assumes: rst_n is low at time zero.
module ep_fifo_window_chk #(
    parameter int NUM_EP    = 16,
    parameter int CNT_W     = 7,
    parameter int PKT_LIMIT = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_req,
    input logic              bus_ready,
    input logic              bus_ack,
    input logic [NUM_EP-1:0] tx_not_empty,
    input logic [NUM_EP-1:0] rx_full,
    input logic              evt_valid,
    input logic [1:0]        evt_kind,
    input logic              ram_we,
    input logic [CNT_W-1:0]  sel_count
);
    // R12: completion happens only with the engine idle.
    p_ack_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ack |-> bus_ready);

    // R12: the acknowledge lasts a single cycle.
    p_ack_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ack |=> !bus_ack);

    // R12: an accepted request makes the engine busy.
    p_accept_busy_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_ready && bus_req) |=> !bus_ready);

    // R5: no buffer count ever goes past the packet limit.
    p_count_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        int'(sel_count) <= PKT_LIMIT);

    // R7: a not-empty flag rises only after a RAM push.
    p_ne_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (|(tx_not_empty & ~$past(tx_not_empty))) |-> $past(ram_we));

    // R8: a full flag rises only after a receive-load event.
    p_full_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (|(rx_full & ~$past(rx_full))) |-> $past(evt_valid && evt_kind == 2'd2));
endmodule

bind ep_fifo_window ep_fifo_window_chk #(
    .NUM_EP   (NUM_EP),
    .CNT_W    (CNT_W),
    .PKT_LIMIT(PKT_LIMIT)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_req     (bus_req),
    .bus_ready   (bus_ready),
    .bus_ack     (bus_ack),
    .tx_not_empty(tx_not_empty),
    .rx_full     (rx_full),
    .evt_valid   (evt_valid),
    .evt_kind    (evt_kind),
    .ram_we      (ram_we),
    .sel_count   (sel_count)
);

// File: tb/ep_fifo_window_tb.sv
// Bench for ep_fifo_window: a vector table walk followed by directed tests
// of reset, timing, packet limits, events and base masking.
module ep_fifo_window_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_req = 1'b0;
    logic        bus_we = 1'b0;
    logic [1:0]  bus_size = 2'd0;
    logic [7:0]  bus_addr = 8'h00;
    logic [31:0] bus_wdata = '0;
    logic        bus_ready;
    logic        bus_ack;
    logic [31:0] bus_rdata;
    logic        evt_valid = 1'b0;
    logic [3:0]  evt_ep = 4'd0;
    logic [1:0]  evt_kind = 2'd3;
    logic [15:0] tx_not_empty;
    logic [15:0] rx_full;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    ep_fifo_window u_dut (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
        .bus_size(bus_size), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_ready(bus_ready), .bus_ack(bus_ack), .bus_rdata(bus_rdata),
        .evt_valid(evt_valid), .evt_ep(evt_ep), .evt_kind(evt_kind),
        .tx_not_empty(tx_not_empty), .rx_full(rx_full)
    );

    // Vector: {we, size, addr, wdata, expected rdata}
    localparam int NVEC = 15;
    localparam logic [74:0] VEC [NVEC] = '{
        {1'b1, 2'd1, 8'h84, 32'h0000_0010, 32'h0},          // ep1 tx base 0x80
        {1'b1, 2'd1, 8'h86, 32'h0000_0010, 32'h0},          // ep1 rx base 0x80
        {1'b0, 2'd1, 8'h84, 32'h0,         32'h0000_0080},  // readback
        {1'b1, 2'd2, 8'h44, 32'hDDCC_BBAA, 32'h0},          // word push
        {1'b1, 2'd1, 8'h46, 32'h0000_2211, 32'h0},          // half push, other offset
        {1'b1, 2'd0, 8'h47, 32'h0000_0033, 32'h0},          // byte push
        {1'b0, 2'd2, 8'h45, 32'h0,         32'hDDCC_BBAA},  // word pop
        {1'b0, 2'd1, 8'h44, 32'h0,         32'h0000_2211},  // half pop
        {1'b0, 2'd0, 8'h44, 32'h0,         32'h0000_0033},  // byte pop
        {1'b0, 2'd2, 8'hC0, 32'h0,         32'h0},          // unmapped read
        {1'b1, 2'd2, 8'h00, 32'hFFFF_FFFF, 32'h0},          // unmapped write
        {1'b0, 2'd1, 8'h86, 32'h0,         32'h0000_0080},  // rx base readback
        {1'b1, 2'd0, 8'h84, 32'h0000_0055, 32'h0},          // byte write to base
        {1'b0, 2'd1, 8'h84, 32'h0,         32'h0000_0080},  // unchanged
        {1'b1, 2'd3, 8'h48, 32'h1234_5678, 32'h0}           // invalid size
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    task automatic acc(input logic we, input logic [1:0] sz, input logic [7:0] ad,
                       input logic [31:0] wd, output logic [31:0] rd,
                       output int lat, output logic busy_ok);
        @(negedge clk);
        bus_req = 1'b1; bus_we = we; bus_size = sz; bus_addr = ad; bus_wdata = wd;
        @(posedge clk);
        @(negedge clk);
        bus_req = 1'b0;
        lat = 0;
        busy_ok = 1'b1;
        if (bus_ready) busy_ok = 1'b0;
        while (!bus_ack) begin
            @(posedge clk);
            lat++;
            @(negedge clk);
            if (!bus_ack && bus_ready) busy_ok = 1'b0;
        end
        rd = bus_rdata;
    endtask

    task automatic event_pulse(input logic [3:0] ep, input logic [1:0] kind);
        @(negedge clk);
        evt_valid = 1'b1; evt_ep = ep; evt_kind = kind;
        @(negedge clk);
        evt_valid = 1'b0; evt_kind = 2'd3;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        int          lat;
        logic        bok;

        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 ready", 32'(bus_ready), 32'h1);
        check("R1 ack", 32'(bus_ack), 32'h0);
        check("R1 tx_not_empty", 32'(tx_not_empty), 32'h0);
        check("R1 rx_full", 32'(rx_full), 32'h0);
        acc(1'b0, 2'd1, 8'h8A, 32'h0, rd, lat, bok);
        check("R1 base reset", rd, 32'h0);
        check("R12 register latency", 32'(lat), 32'd2);

        // Table walk: R2 R3 R4 R9 R11
        for (int i = 0; i < NVEC; i++) begin
            logic        v_we;
            logic [1:0]  v_sz;
            logic [7:0]  v_ad;
            logic [31:0] v_wd;
            logic [31:0] v_ex;
            {v_we, v_sz, v_ad, v_wd, v_ex} = VEC[i];
            acc(v_we, v_sz, v_ad, v_wd, rd, lat, bok);
            if (!v_we)
                check($sformatf("R2 R3 R4 R9 R11 vector %0d", i), rd, v_ex);
            check($sformatf("R12 busy vector %0d", i), 32'(bok), 32'h1);
        end
        check("R7 R11 only ep1 not empty", 32'(tx_not_empty), 32'h0000_0002);

        // R10: advance both ep1 buffers, then probe the next byte position
        event_pulse(4'd1, 2'd1);
        event_pulse(4'd1, 2'd0);
        check("R7 done clears not-empty", 32'(tx_not_empty), 32'h0);
        acc(1'b1, 2'd0, 8'h44, 32'h77, rd, lat, bok);
        check("R12 byte write latency", 32'(lat), 32'd2);
        acc(1'b0, 2'd0, 8'h44, 32'h0, rd, lat, bok);
        check("R10 next packet start", rd, 32'h0000_0077);

        // R8: load sets full, a pop clears it
        event_pulse(4'd3, 2'd2);
        check("R8 load sets full", 32'(rx_full), 32'h0000_0008);
        acc(1'b0, 2'd0, 8'h4C, 32'h0, rd, lat, bok);
        check("R8 pop clears full", 32'(rx_full), 32'h0);

        // R5 R6: a 64-byte packet on ep2 at 0x200
        acc(1'b1, 2'd1, 8'h88, 32'h0040, rd, lat, bok);
        acc(1'b1, 2'd1, 8'h8A, 32'h0040, rd, lat, bok);
        for (int k = 0; k < 16; k++) begin
            logic [31:0] w;
            w = {8'(4*k+3), 8'(4*k+2), 8'(4*k+1), 8'(4*k)};
            acc(1'b1, 2'd2, 8'h48, w, rd, lat, bok);
            if (k == 0) check("R12 word latency", 32'(lat), 32'd5);
        end
        acc(1'b1, 2'd0, 8'h48, 32'hEE, rd, lat, bok);
        for (int k = 0; k < 16; k++) begin
            logic [31:0] w;
            w = {8'(4*k+3), 8'(4*k+2), 8'(4*k+1), 8'(4*k)};
            acc(1'b0, 2'd2, 8'h4A, 32'h0, rd, lat, bok);
            if (k == 0 || k == 15) check($sformatf("R3 R4 full packet word %0d", k), rd, w);
        end
        acc(1'b0, 2'd2, 8'h48, 32'h0, rd, lat, bok);
        check("R6 pop past limit", rd, 32'h0);
        event_pulse(4'd2, 2'd0);
        acc(1'b1, 2'd0, 8'h48, 32'h99, rd, lat, bok);
        event_pulse(4'd2, 2'd1);
        acc(1'b0, 2'd0, 8'h48, 32'h0, rd, lat, bok);
        check("R5 R6 counts held at limit", rd, 32'h0000_0099);

        // R9 base masking
        acc(1'b1, 2'd1, 8'h94, 32'hFFFF, rd, lat, bok);
        acc(1'b0, 2'd1, 8'h94, 32'h0, rd, lat, bok);
        check("R9 base mask", rd, 32'h0000_07F8);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule